// File: doc/BRIEF.md
# Serial Segment Display Loader

The loader takes one parallel display image of `FRAME_W` bits (96 by default) and sends it bit by bit into a chain of external shift-register and latch driver chips. The chain behaves as one long shift register feeding an equally wide output latch. The loader drives three lines into it: a serial data line, a shift clock and a latch strobe. A one in the image lights the matching segment and a zero turns it off. Shifting does not disturb the visible image. The image changes only when the loader pulses the latch strobe once, after a complete frame has been shifted in.

Frames enter through a valid/ready stream port. A frame is taken on any clock edge where `frm_valid` and `frm_ready` are both high. The loader holds one frame that is being shifted and at most one waiting frame. While the waiting slot is occupied, `frm_ready` stays low. The sender must then keep `frm_valid` high and `frm_data` unchanged until the frame is accepted. A waiting frame starts only after the current latch pulse has ended, so a frame in flight is never cut short. A blanking output stays high for as long as reset is applied, which keeps every segment dark during power-up.

The shift clock runs at the system clock divided by `2*HALF_DIV`. Each level of the shift clock lasts `HALF_DIV` system cycles. Data changes only on falling edges of the shift clock, so it is stable at every rising edge.

Top module: `seg_chain_loader`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `ser_clk`, `lat_en`, `busy`, `done` and `frm_ready` are 0. A frame that was partly shifted when reset came is abandoned and never latched.
- R2: Bits leave most significant first. The k-th rising edge of `ser_clk` in a frame (k = 1..FRAME_W) carries bit FRAME_W-k of the image, so bit FRAME_W-1 ends at the far end of the chain.
- R3: `ser_dat` changes only while `ser_clk` is low. It has the same value in the cycle before and the cycle of each rising edge of `ser_clk`.
- R4: Within a frame, every high phase of `ser_clk` and every low phase between two rising edges lasts exactly `HALF_DIV` system cycles.
- R5: Exactly FRAME_W rising edges of `ser_clk` occur between two latch pulses.
- R6: `lat_en` rises `HALF_DIV` cycles after the last falling edge of the frame. It stays high for exactly `2*HALF_DIV` cycles, and `ser_clk` stays low throughout.
- R7: `frm_ready` is high exactly when reset is released and no frame is waiting. After an accepted frame, `frm_ready` is low in the next cycle. While `frm_valid` is low, data on `frm_data` starts nothing.
- R8: Frames are latched in the order they were accepted. A frame accepted during shifting waits and is sent in full after the current latch pulse.
- R9: `done` is a one-cycle pulse in the first cycle after `lat_en` falls. `busy` is high from the cycle after a frame is taken until that cycle.
- R10: `seg_blank` is 1 during reset and drops to 0 on the first clock edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| frm_valid | input | 1 | Frame offered on `frm_data` |
| frm_ready | output | 1 | Loader can accept a frame this cycle |
| frm_data | input | FRAME_W | Display image, one bit per segment, 1 = lit |
| ser_dat | output | 1 | Serial data into the driver chain |
| ser_clk | output | 1 | Shift clock of the driver chain |
| lat_en | output | 1 | Latch strobe, moves the shifted frame to the outputs |
| seg_blank | output | 1 | Blanks all segments while high |
| busy | output | 1 | A frame is being shifted or latched |
| done | output | 1 | One-cycle pulse when a latch pulse has ended |

## Verification
The hardest case to reach is back-pressure with one frame shifting, a second frame waiting and a third frame offered. The stimulus reaches it by offering frames back to back without waiting, so the sender stalls on a low `frm_ready`. The bench then checks that the stalled frame is accepted only after a latch pulse, and that all three frames are latched in their original order. A second hard case is reset arriving partway through a frame. The bench asserts reset after a fixed number of shift cycles and confirms that the truncated frame never produces a latch pulse.

// File: rtl/seg_loader_pkg.sv
package seg_loader_pkg;

  // Phases of the serial engine
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LOW   = 3'd1,
    ST_HIGH  = 3'd2,
    ST_GAP   = 3'd3,
    ST_LATCH = 3'd4
  } eng_state_t;

endpackage

// File: rtl/seg_half_tick.sv
module seg_half_tick #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] TOP = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
    end else if (cnt_q == TOP) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign tick = run && (cnt_q == TOP);

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst) cnt_q <= TOP); // R4

endmodule

// File: rtl/seg_frame_slot.sv
module seg_frame_slot #(
  parameter int FRAME_W = 96
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               open,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [FRAME_W-1:0] in_data,
  input  logic               take,
  output logic               full,
  output logic [FRAME_W-1:0] data
);
  logic accept;

  assign in_ready = open && !full;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      full <= 1'b0;
      data <= '0;
    end else if (take) begin
      full <= 1'b0;
    end else if (accept) begin
      full <= 1'b1;
      data <= in_data;
    end
  end

  AST_HOLD_PENDING: assert property (@(posedge clk) disable iff (rst) (full && !take) |=> (full && $stable(data))); // R8

endmodule

// File: rtl/seg_shift_engine.sv
module seg_shift_engine
  import seg_loader_pkg::*;
#(
  parameter int FRAME_W = 96
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  input  logic               slot_full,
  input  logic [FRAME_W-1:0] slot_data,
  output logic               take,
  output logic               run,
  output logic               ser_dat,
  output logic               ser_clk,
  output logic               lat_en,
  output logic               done
);
  localparam int IW = (FRAME_W > 1) ? $clog2(FRAME_W) : 1;
  localparam logic [IW-1:0] LAST = IW'(FRAME_W - 1);

  eng_state_t         state_q;
  logic [FRAME_W-1:0] sh_q;
  logic [IW-1:0]      idx_q;
  logic               ph_q;

  assign take    = (state_q == ST_IDLE) && slot_full;
  assign run     = (state_q != ST_IDLE);
  assign ser_dat = sh_q[FRAME_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      sh_q    <= '0;
      idx_q   <= '0;
      ph_q    <= 1'b0;
      ser_clk <= 1'b0;
      lat_en  <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (slot_full) begin
            sh_q    <= slot_data;
            idx_q   <= '0;
            state_q <= ST_LOW;
          end
        end
        ST_LOW: begin
          if (tick) begin
            ser_clk <= 1'b1;
            state_q <= ST_HIGH;
          end
        end
        ST_HIGH: begin
          if (tick) begin
            ser_clk <= 1'b0;
            if (idx_q == LAST) begin
              state_q <= ST_GAP;
            end else begin
              sh_q    <= {sh_q[FRAME_W-2:0], 1'b0};
              idx_q   <= idx_q + 1'b1;
              state_q <= ST_LOW;
            end
          end
        end
        ST_GAP: begin
          if (tick) begin
            lat_en  <= 1'b1;
            ph_q    <= 1'b0;
            state_q <= ST_LATCH;
          end
        end
        ST_LATCH: begin
          if (tick) begin
            if (!ph_q) begin
              ph_q <= 1'b1;
            end else begin
              lat_en  <= 1'b0;
              done    <= 1'b1;
              state_q <= ST_IDLE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_DAT_LOW_ONLY:   assert property (@(posedge clk) disable iff (rst) $changed(ser_dat) |-> !ser_clk); // R3
  AST_RISE_STABLE:    assert property (@(posedge clk) disable iff (rst) $rose(ser_clk) |-> $stable(ser_dat)); // R3
  AST_LAT_CLK_LOW:    assert property (@(posedge clk) disable iff (rst) lat_en |-> !ser_clk); // R6
  AST_DONE_AFTER_LAT: assert property (@(posedge clk) disable iff (rst) done |-> (!lat_en && $past(lat_en))); // R9
  AST_BUSY_IN_LAT:    assert property (@(posedge clk) disable iff (rst) lat_en |-> run); // R9
  AST_BIT_RANGE:      assert property (@(posedge clk) disable iff (rst) idx_q <= LAST); // R5

endmodule

// File: rtl/seg_chain_loader.sv
module seg_chain_loader #(
  parameter int FRAME_W  = 96,
  parameter int HALF_DIV = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               frm_valid,
  output logic               frm_ready,
  input  logic [FRAME_W-1:0] frm_data,
  output logic               ser_dat,
  output logic               ser_clk,
  output logic               lat_en,
  output logic               seg_blank,
  output logic               busy,
  output logic               done
);
  logic               tick;
  logic               run;
  logic               take;
  logic               slot_full;
  logic [FRAME_W-1:0] slot_data;

  always_ff @(posedge clk) begin
    if (rst) seg_blank <= 1'b1;
    else     seg_blank <= 1'b0;
  end

  seg_frame_slot #(.FRAME_W(FRAME_W)) u_slot (
    .clk      (clk),
    .rst      (rst),
    .open     (!seg_blank),
    .in_valid (frm_valid),
    .in_ready (frm_ready),
    .in_data  (frm_data),
    .take     (take),
    .full     (slot_full),
    .data     (slot_data)
  );

  seg_half_tick #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .run  (run),
    .tick (tick)
  );

  seg_shift_engine #(.FRAME_W(FRAME_W)) u_eng (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .slot_full (slot_full),
    .slot_data (slot_data),
    .take      (take),
    .run       (run),
    .ser_dat   (ser_dat),
    .ser_clk   (ser_clk),
    .lat_en    (lat_en),
    .done      (done)
  );

  assign busy = run;

  AST_BLANK_IN_RST: assert property (@(posedge clk) rst |=> seg_blank); // R10
  AST_ACCEPT_CLOSE: assert property (@(posedge clk) disable iff (rst) (frm_valid && frm_ready) |=> !frm_ready); // R7

endmodule

// File: tb/tb_seg_chain_loader.sv
module tb_seg_chain_loader;
  localparam int W = 96;
  localparam int H = 2;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         frm_valid = 1'b0;
  logic         frm_ready;
  logic [W-1:0] frm_data = '0;
  logic         ser_dat, ser_clk, lat_en, seg_blank, busy, done;

  seg_chain_loader #(.FRAME_W(W), .HALF_DIV(H)) dut (
    .clk(clk), .rst(rst), .frm_valid(frm_valid), .frm_ready(frm_ready),
    .frm_data(frm_data), .ser_dat(ser_dat), .ser_clk(ser_clk), .lat_en(lat_en),
    .seg_blank(seg_blank), .busy(busy), .done(done)
  );

  always #10 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // expected frame queue
  logic [W-1:0] exp_q [0:31];
  int head = 0;
  int tail = 0;
  int n_latched = 0;

  // monitor state
  logic         p_clk = 1'b0, p_dat = 1'b0, p_lat = 1'b0;
  int           rise_cnt = 0, run_len = 0, since_fall = 0, lat_run = 0;
  logic [W-1:0] cap = '0;

  always @(negedge clk) begin
    if (rst) begin
      rise_cnt = 0; run_len = 0; since_fall = 0; lat_run = 0; cap = '0;
    end else begin
      if (lat_en && !p_lat) begin
        chk(rise_cnt == W, "R5 edges per frame", W'(rise_cnt), W'(W));
        chk(head != tail, "R8 latch with no frame pending", W'(tail - head), W'(1));
        chk(cap == exp_q[head % 32], "R2 R8 shifted image", cap, exp_q[head % 32]);
        chk(since_fall == H, "R6 gap before latch", W'(since_fall), W'(H));
        chk(busy == 1'b1, "R9 busy during latch", W'(busy), W'(1));
        lat_run = 1;
      end else if (lat_en && p_lat) begin
        lat_run++;
      end else if (!lat_en && p_lat) begin
        chk(lat_run == 2 * H, "R6 latch width", W'(lat_run), W'(2 * H));
        chk(done == 1'b1, "R9 done after latch", W'(done), W'(1));
        chk(busy == 1'b0, "R9 busy cleared", W'(busy), W'(0));
        head++; n_latched++; rise_cnt = 0;
      end
      if (done && !(!lat_en && p_lat))
        chk(1'b0, "R9 stray done", W'(1), W'(0));

      if (ser_clk && !p_clk) begin
        chk(ser_dat == p_dat, "R3 data stable at rise", W'(ser_dat), W'(p_dat));
        if (rise_cnt > 0) chk(run_len == H, "R4 low phase", W'(run_len), W'(H));
        cap = {cap[W-2:0], ser_dat};
        rise_cnt++;
        run_len = 1;
        since_fall++;
      end else if (!ser_clk && p_clk) begin
        chk(run_len == H, "R4 high phase", W'(run_len), W'(H));
        run_len = 1;
        since_fall = 1;
      end else begin
        run_len++;
        since_fall++;
      end
    end
    p_clk = ser_clk; p_dat = ser_dat; p_lat = lat_en;
  end

  task automatic send(input logic [W-1:0] f);
    @(negedge clk);
    frm_valid = 1'b1;
    frm_data  = f;
    forever begin
      if (frm_ready) begin
        exp_q[tail % 32] = f;
        tail++;
        @(negedge clk);
        frm_valid = 1'b0;
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic drain();
    while (head != tail || busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [W-1:0] pat(input int kind, input int k);
    logic [W-1:0] f = '0;
    for (int i = 0; i < W; i++) begin
      case (kind)
        0: f[i] = (i == k);
        1: f[i] = (i != k);
        default: f[i] = (((i * i + k * 5) % 3) == 0);
      endcase
    end
    return f;
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    int lat_at_accept;
    repeat (3) @(negedge clk);
    // R1 R10 reset state
    chk(seg_blank == 1'b1, "R10 blank in reset", W'(seg_blank), W'(1));
    chk(ser_clk == 1'b0 && lat_en == 1'b0, "R1 lines low in reset", W'({ser_clk, lat_en}), W'(0));
    chk(busy == 1'b0 && done == 1'b0 && frm_ready == 1'b0, "R1 status in reset", W'({busy, done, frm_ready}), W'(0));
    rst = 1'b0;
    @(negedge clk);
    chk(seg_blank == 1'b0, "R10 blank released", W'(seg_blank), W'(0));
    chk(frm_ready == 1'b1, "R7 ready after reset", W'(frm_ready), W'(1));

    // R7 data without valid is ignored
    for (int i = 0; i < 40; i++) begin
      frm_data = pat(2, i);
      @(negedge clk);
    end
    chk(busy == 1'b0 && n_latched == 0, "R7 no start without valid", W'(busy), W'(0));

    // flat patterns and walking bits, including both ends of the image
    send('0);
    send('1);
    send({(W/2){2'b10}});
    for (int k = 0; k < W; k += 7) send(pat(0, k));
    send(pat(0, W - 1));
    send(pat(1, 0));
    send(pat(1, W - 1));
    for (int k = 0; k < 4; k++) send(pat(2, k));
    drain();
    chk(n_latched == tail, "R8 every frame latched once", W'(n_latched), W'(tail));

    // R7 R8 back-pressure: one shifting, one waiting, third stalls
    send(pat(2, 11));
    while (!busy) @(negedge clk);
    send(pat(2, 12));
    chk(frm_ready == 1'b0, "R7 ready low while slot held", W'(frm_ready), W'(0));
    lat_at_accept = n_latched;
    send(pat(2, 13));
    chk(n_latched > lat_at_accept, "R8 held frame waits for latch", W'(n_latched), W'(lat_at_accept + 1));
    drain();
    chk(head == tail, "R8 all queued frames latched in order", W'(tail - head), W'(0));

    // R1 reset partway through a frame
    send(pat(0, 40));
    send(pat(0, 41));
    repeat (150) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    head = 0; tail = 0;
    chk(seg_blank == 1'b1, "R10 blank on mid-frame reset", W'(seg_blank), W'(1));
    chk(ser_clk == 1'b0 && lat_en == 1'b0 && busy == 1'b0, "R1 abandon frame", W'({ser_clk, lat_en, busy}), W'(0));
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(seg_blank == 1'b0 && frm_ready == 1'b1, "R10 R1 recover", W'({seg_blank, frm_ready}), W'(2'b01));
    repeat (600) @(negedge clk);
    chk(busy == 1'b0 && head == 0, "R1 no latch of abandoned frames", W'(head), W'(0));
    send(pat(0, 3));
    drain();
    chk(head == 1, "R2 frame after reset", W'(head), W'(1));

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule